// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Sequencer

This block is the control path of a core with separate program and data memories. It keeps the program counter, drives the program memory address, and latches each fetched 14-bit instruction word into an execute register. While one word sits in execute, the next one is fetched, so in steady state one instruction finishes every instruction cycle. The `step_en` input marks each instruction cycle, and the whole pipeline moves forward only on those cycles.

Decode logic outside the block looks at the word in execute. It returns a two-bit flow code and a 13-bit target. Three codes change control flow: jump, call and return. Any of them discards the word that was fetched behind it by replacing it with a forced no-op, and redirects the fetch. The redirect therefore costs one extra cycle. A call saves the address of its successor in an eight-entry circular return stack. A return takes the most recent entry from that stack.

Top module: `fetch_exec_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads `pm_addr` = 0, `ex_word` = 14'h0000 (the no-op encoding) and `ex_nop` = 1. The first cycle after reset therefore fetches address 0 and executes only a no-op.
- R2: On an edge with `step_en` = 1 and no redirect taken:
  - `ex_word` takes `fetch_word`;
  - `ex_nop` goes to 0;
  - `pm_addr` increases by one.
- R3: On an edge with `step_en` = 0, `pm_addr`, `ex_word` and `ex_nop` keep their values whatever the other inputs are.
- R4: Flow code 2'b01 (jump) while `ex_nop` = 0 and `step_en` = 1 loads `flow_tgt` into `pm_addr`, and replaces the fetched word with a no-op (`ex_word` = 0, `ex_nop` = 1).
- R5: While `ex_nop` = 1, the flow code is ignored: the cycle behaves as in R2.
- R6: Flow code 2'b10 (call) pushes the current `pm_addr` (the address after the call) onto the return stack. It then redirects to `flow_tgt` with a flush, as in R4.
- R7: Flow code 2'b11 (return) pops the newest stack entry into `pm_addr` and flushes the fetched word.
- R8: The return stack holds 8 entries in a circle. A ninth push overwrites the oldest entry and raises no flag. Eight pops then return the last eight pushes, newest first, and a further pop returns the ninth push again.
- R9: `pm_addr` wraps from 13'h1FFF to 0 on a sequential advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Instruction-cycle enable; advances the pipeline |
| fetch_word | input | 14 | Program memory word at `pm_addr` |
| flow_op | input | 2 | Flow code for the word in execute: 00 none, 01 jump, 10 call, 11 return |
| flow_tgt | input | 13 | Jump or call destination |
| pm_addr | output | 13 | Program memory fetch address (the program counter) |
| ex_word | output | 14 | Instruction word presented to execute |
| ex_nop | output | 1 | High when `ex_word` is a forced no-op |

## Verification
The bench builds the block with its default sizes: 13-bit addresses, 14-bit words and 8 stack entries. With these sizes a short run can reach the top address and show the wrap to zero. It can also push nine calls to overrun the stack and unwind it completely. The program memory is modelled as a word derived from its own address, so every word fetched or flushed can be told apart from the no-op encoding.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic [1:0] {
    FLOW_NONE = 2'b00,
    FLOW_JUMP = 2'b01,
    FLOW_CALL = 2'b10,
    FLOW_RET  = 2'b11
  } flow_e;
endpackage

// File: rtl/fx_ret_stack.sv
module fx_ret_stack #(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  // rd_ptr is the slot just below the write pointer, with circular wrap
  assign rd_ptr   = (wr_ptr == '0) ? LAST : wr_ptr - PW'(1);
  assign top_addr = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
    end else if (push) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
    end else if (pop) begin
      wr_ptr <= rd_ptr;
    end
  end
endmodule

// File: rtl/fx_pc_unit.sv
module fx_pc_unit #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (adv)  pc <= load ? load_addr : pc + AW'(1);
  end
endmodule

// File: rtl/fx_exec_reg.sv
module fx_exec_reg #(
  parameter int            IW  = 14,
  parameter logic [IW-1:0] NOP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          flush,
  input  logic [IW-1:0] fetch_word,
  output logic [IW-1:0] ex_word,
  output logic          ex_nop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_word <= NOP;
      ex_nop  <= 1'b1;
    end else if (adv) begin
      ex_word <= flush ? NOP : fetch_word;
      ex_nop  <= flush;
    end
  end
endmodule

// File: rtl/fetch_exec_ctrl.sv
module fetch_exec_ctrl #(
  parameter int            AW    = 13,
  parameter int            IW    = 14,
  parameter int            DEPTH = 8,
  parameter logic [IW-1:0] NOP   = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic [IW-1:0] fetch_word,
  input  logic [1:0]    flow_op,
  input  logic [AW-1:0] flow_tgt,
  output logic [AW-1:0] pm_addr,
  output logic [IW-1:0] ex_word,
  output logic          ex_nop
);
  import fx_pkg::*;

  flow_e         op;
  logic          redirect;
  logic          do_push;
  logic          do_pop;
  logic [AW-1:0] stack_top;
  logic [AW-1:0] next_tgt;

  assign op       = flow_e'(flow_op);
  assign redirect = step_en && !ex_nop && (op != FLOW_NONE);
  assign do_push  = redirect && (op == FLOW_CALL);
  assign do_pop   = redirect && (op == FLOW_RET);
  assign next_tgt = (op == FLOW_RET) ? stack_top : flow_tgt;

  fx_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .push_addr (pm_addr),
    .top_addr  (stack_top)
  );

  fx_pc_unit #(.AW(AW)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .adv       (step_en),
    .load      (redirect),
    .load_addr (next_tgt),
    .pc        (pm_addr)
  );

  fx_exec_reg #(.IW(IW), .NOP(NOP)) u_ex (
    .clk        (clk),
    .rst        (rst),
    .adv        (step_en),
    .flush      (redirect),
    .fetch_word (fetch_word),
    .ex_word    (ex_word),
    .ex_nop     (ex_nop)
  );
endmodule

// File: rtl/fx_checker.sv
module fx_checker #(
  parameter int            AW  = 13,
  parameter int            IW  = 14,
  parameter logic [IW-1:0] NOP = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          step_en,
  input logic [1:0]    flow_op,
  input logic [AW-1:0] flow_tgt,
  input logic [AW-1:0] pm_addr,
  input logic [IW-1:0] ex_word,
  input logic          ex_nop
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pm_addr) && $stable(ex_word) && $stable(ex_nop)); // R3

  AST_SEQ_ADV: assert property (@(posedge clk) disable iff (rst)
    step_en && (flow_op == 2'b00) |=> (pm_addr == AW'($past(pm_addr) + 1'b1)) && !ex_nop); // R2

  AST_NOP_IGNORES_FLOW: assert property (@(posedge clk) disable iff (rst)
    step_en && ex_nop |=> !ex_nop && (pm_addr == AW'($past(pm_addr) + 1'b1))); // R5

  AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (rst)
    step_en && !ex_nop && (flow_op == 2'b01) |=> ex_nop && (pm_addr == $past(flow_tgt))); // R4

  AST_CALL_FLUSH: assert property (@(posedge clk) disable iff (rst)
    step_en && !ex_nop && (flow_op == 2'b10) |=> ex_nop && (pm_addr == $past(flow_tgt))); // R6

  AST_RET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    step_en && !ex_nop && (flow_op == 2'b11) |=> ex_nop); // R7

  AST_NOP_WORD: assert property (@(posedge clk) disable iff (rst)
    ex_nop |-> ex_word == NOP); // R4
endmodule

bind fetch_exec_ctrl fx_checker #(.AW(AW), .IW(IW), .NOP(NOP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step_en  (step_en),
  .flow_op  (flow_op),
  .flow_tgt (flow_tgt),
  .pm_addr  (pm_addr),
  .ex_word  (ex_word),
  .ex_nop   (ex_nop)
);

// File: tb/sim_fetch_exec_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_exec_ctrl;
  localparam int AW = 13;
  localparam int IW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_en = 1'b0;
  logic [IW-1:0] fetch_word;
  logic [1:0]    flow_op = 2'b00;
  logic [AW-1:0] flow_tgt = '0;
  logic [AW-1:0] pm_addr;
  logic [IW-1:0] ex_word;
  logic          ex_nop;

  always #2 clk = ~clk;

  // program memory model: every word carries its own address, never zero
  assign fetch_word = {1'b1, pm_addr};

  fetch_exec_ctrl u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .fetch_word(fetch_word),
    .flow_op(flow_op), .flow_tgt(flow_tgt),
    .pm_addr(pm_addr), .ex_word(ex_word), .ex_nop(ex_nop)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [IW-1:0] word;
    logic          nop;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic [AW-1:0] m_pc;
  logic [IW-1:0] m_word;
  logic          m_nop;
  logic [AW-1:0] m_stk [8];
  int            m_sp;

  task automatic cmp(input string tag, input logic [AW-1:0] a, input logic [IW-1:0] w, input logic n);
    n_cmp++;
    if (pm_addr !== a || ex_word !== w || ex_nop !== n) begin
      n_bad++;
      $display("FAIL %s: got addr=%h word=%h nop=%b, expected addr=%h word=%h nop=%b",
               tag, pm_addr, ex_word, ex_nop, a, w, n);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [AW-1:0] tgt, input bit en, input string tag);
    exp_t e;
    @(negedge clk);
    flow_op  = op;
    flow_tgt = tgt;
    step_en  = en;
    if (en) begin
      if (op != 2'b00 && !m_nop) begin
        case (op)
          2'b10: begin m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = tgt; end
          2'b11: begin m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; end
          default: m_pc = tgt;
        endcase
        m_word = '0;
        m_nop  = 1'b1;
      end else begin
        m_word = {1'b1, m_pc};
        m_nop  = 1'b0;
        m_pc   = m_pc + 1'b1;
      end
    end
    e.addr = m_pc; e.word = m_word; e.nop = m_nop; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares just after the edge that consumed the queued item
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp(e.tag, e.addr, e.word, e.nop);
    end
  end

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_pc = '0; m_word = '0; m_nop = 1'b1; m_sp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 reset state", '0, '0, 1'b1);

    step(2'b00, '0, 1, "R2 first fetch");
    step(2'b00, '0, 1, "R2 advance");
    step(2'b00, '0, 1, "R2 advance");
    step(2'b01, 13'h0AA, 0, "R3 hold with jump code");
    step(2'b10, 13'h0BB, 0, "R3 hold with call code");
    step(2'b01, 13'h100, 1, "R4 jump");
    step(2'b01, 13'h155, 1, "R5 jump ignored on nop");
    step(2'b10, 13'h200, 1, "R6 call");
    step(2'b11, '0,      1, "R5 return ignored on nop");
    step(2'b11, '0,      1, "R7 return");
    step(2'b00, '0,      1, "R7 resume after return");

    for (int i = 0; i < 9; i++) begin
      step(2'b10, AW'(13'h300 + i * 16), 1, "R8 call fill");
      step(2'b00, '0, 1, "R8 callee fetch");
    end
    for (int i = 0; i < 9; i++) begin
      step(2'b11, '0, 1, "R8 return unwind");
      step(2'b00, '0, 1, "R8 after return");
    end

    step(2'b01, 13'h1FFE, 1, "R4 jump near top");
    step(2'b00, '0, 1, "R9 reach top");
    step(2'b00, '0, 1, "R9 wrap to zero");
    step(2'b00, '0, 1, "R9 after wrap");

    @(negedge clk);
    step_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule